// File: doc/BRIEF.md
# Signed-Magnitude Floating-Point Adder/Subtractor (32-bit, explicit-bit mantissa)

This block adds or subtracts two 32-bit floating-point words. The word format is not IEEE. Each word has a sign bit, a 10-bit biased exponent and a 21-bit fraction. The fraction stores its leading one explicitly, so a normalized fraction has a value in [0.5, 1). The exponent is biased by 512. Every encoding from 0 to 1023 is therefore an ordinary normal exponent, and no values are reserved for special cases.

The unit does the following in order:

- It picks the operand with the larger magnitude.
- It shifts the other operand's fraction right to align the two.
- It adds or subtracts the magnitudes.
- It renormalizes the result in either direction.
- It checks that the result's exponent is still in range.

Truncation toward zero is the only rounding. Guard bits and a sticky bit make the truncated result match the exact sum truncated to 21 fraction bits. A result that is too large saturates and raises an overflow flag. A nonzero result that is too small is flushed to zero and raises an underflow flag.

Operands are presented on a cycle. With the default configuration, the result and both flags appear on the outputs after the next rising clock edge.

Top module: `fp_addsub`

## Requirements
- R1: A word holds the sign in bit 31 (0 positive, 1 negative), the biased exponent in bits 30:21 and the fraction in bits 20:0. Its value is (-1)^sign × 0.fraction × 2^(exponent − 512), and bit 20 carries weight 0.5.
- R2: Results and flags are registered. They appear one clock edge after the operands are driven. While the active-low reset is held, the result word is all-zero and both flags are low.
- R3: The operand with the smaller exponent is aligned to the larger one before combining. The returned fraction is the exact sum truncated toward zero to 21 bits, including any bits that the alignment shifted out.
- R4: When op_sub is 1, the sign of op_b is inverted before combining. With unequal magnitudes, the result sign is that of the larger-magnitude operand.
- R5: When the aligned magnitudes sum to 1.0 or more, the fraction is shifted right by one and the exponent is incremented.
- R6: A result below 0.5 is shifted left until bit 20 is 1, and the exponent drops by one per shift. Every nonzero output has bit 20 set.
- R7: An operand whose fraction field is zero is treated as zero, whatever its sign and exponent. The result is then the other operand, with its sign inverted if it is op_b and op_sub is 1.
- R8: Operands of equal magnitude that cancel give the all-zero word, with both flags low.
- R9: If the result magnitude exceeds (1 − 2^-21) × 2^511, ovf is 1 and the output is the largest magnitude (exponent 1023, fraction all ones) with the result's sign.
- R10: If a nonzero result falls below 0.5 × 2^-512, unf is 1 and the output is the all-zero word.
- R11: ovf and unf are never both 1, and both are 0 for every in-range result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| op_sub | input | 1 | 1 computes op_a − op_b, 0 computes op_a + op_b |
| res | output | 32 | Result word |
| ovf | output | 1 | Result was too large and has been saturated |
| unf | output | 1 | Nonzero result was too small and has been flushed to zero |

## Verification
The hardest case to produce from the ports is the sticky bit changing a truncated result. For that, the bits shifted out during alignment must be nonzero, the operation must be a true subtraction, and the result must then move left by one place. The stimulus subtracts a fraction of all ones, placed 30 binades below the other operand, from an exact 0.5. A correct design returns exponent 511 with fraction 0x1FFFFF. A design that drops the sticky bit returns 0.5 unchanged. Long cancellations to a single surviving bit, and edge underflow at exponent 0, are reached by subtracting neighbouring fractions at a fixed exponent.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
   // Extra low-order bits carried through alignment: guard, round, sticky.
   localparam int unsigned FPAS_GRD = 3;

   typedef enum logic {
      MAG_ADD = 1'b0,
      MAG_SUB = 1'b1
   } mag_op_e;
endpackage

// File: rtl/fpas_order.sv
module fpas_order #(
   parameter int unsigned EXP_W = 10,
   parameter int unsigned MAN_W = 21,
   localparam int unsigned WORD_W = 1 + EXP_W + MAN_W
) (
   input  logic [WORD_W-1:0] a_word,
   input  logic [WORD_W-1:0] b_word,
   input  logic              sub_req,
   output logic              big_sign,
   output logic [EXP_W-1:0]  big_exp,
   output logic [MAN_W-1:0]  big_man,
   output logic [MAN_W-1:0]  small_man,
   output logic [EXP_W-1:0]  exp_gap,
   output fpas_pkg::mag_op_e mag_op
);
   localparam int unsigned KEY_W = EXP_W + MAN_W;

   logic              a_is_zero, b_is_zero, a_wins;
   logic              sa, sb;
   logic [KEY_W-1:0]  key_a, key_b;
   logic [EXP_W-1:0]  small_exp;

   assign a_is_zero = (a_word[MAN_W-1:0] == '0);
   assign b_is_zero = (b_word[MAN_W-1:0] == '0);
   assign sa        = a_word[WORD_W-1];
   assign sb        = b_word[WORD_W-1] ^ sub_req;

   // A zero operand sorts below every nonzero one, whatever its exponent.
   assign key_a  = a_is_zero ? '0 : a_word[KEY_W-1:0];
   assign key_b  = b_is_zero ? '0 : b_word[KEY_W-1:0];
   assign a_wins = (key_a >= key_b);

   always_comb begin
      if (a_wins) begin
         big_sign  = sa;
         big_exp   = a_word[KEY_W-1:MAN_W];
         big_man   = a_word[MAN_W-1:0];
         small_man = b_word[MAN_W-1:0];
         small_exp = b_word[KEY_W-1:MAN_W];
      end else begin
         big_sign  = sb;
         big_exp   = b_word[KEY_W-1:MAN_W];
         big_man   = b_word[MAN_W-1:0];
         small_man = a_word[MAN_W-1:0];
         small_exp = a_word[KEY_W-1:MAN_W];
      end
   end

   assign exp_gap = big_exp - small_exp;
   assign mag_op  = (sa ^ sb) ? fpas_pkg::MAG_SUB : fpas_pkg::MAG_ADD;
endmodule

// File: rtl/fpas_align.sv
module fpas_align #(
   parameter int unsigned EXP_W = 10,
   parameter int unsigned MAN_W = 21,
   parameter int unsigned GRD_W = 3,
   localparam int unsigned EXT_W = MAN_W + GRD_W
) (
   input  logic [MAN_W-1:0] man_in,
   input  logic [EXP_W-1:0] shift,
   output logic [EXT_W-1:0] ext_out
);
   logic [EXT_W-1:0] full, moved, lost_mask;
   logic             sticky;

   assign full = {man_in, {GRD_W{1'b0}}};

   always_comb begin
      if (shift >= EXP_W'(EXT_W)) begin
         moved     = '0;
         lost_mask = '1;
      end else begin
         moved     = full >> shift;
         lost_mask = (EXT_W'(1) << shift) - EXT_W'(1);
      end
      sticky  = |(full & lost_mask);
      ext_out = moved | EXT_W'(sticky);
   end
endmodule

// File: rtl/fpas_norm.sv
module fpas_norm #(
   parameter int unsigned EXP_W = 10,
   parameter int unsigned MAN_W = 21,
   parameter int unsigned GRD_W = 3,
   localparam int unsigned EXT_W  = MAN_W + GRD_W,
   localparam int unsigned LZ_W   = $clog2(EXT_W + 1),
   localparam int unsigned ES_W   = EXP_W + 2,
   localparam int unsigned WORD_W = 1 + EXP_W + MAN_W
) (
   input  logic [EXT_W:0]    sum,
   input  logic [EXP_W-1:0]  base_exp,
   input  logic              sign,
   output logic [WORD_W-1:0] word,
   output logic              ovf,
   output logic              unf
);
   localparam logic signed [ES_W-1:0] EXP_TOP = ES_W'((1 << EXP_W) - 1);

   logic [LZ_W-1:0]        lz;
   logic [EXT_W-1:0]       lifted;
   logic [MAN_W-1:0]       man;
   logic signed [ES_W-1:0] exp_s;
   logic                   carry, is_zero;

   assign carry   = sum[EXT_W];
   assign is_zero = (sum == '0);

   always_comb begin
      lz = LZ_W'(EXT_W);
      for (int i = 0; i < EXT_W; i++) begin
         if (sum[i]) lz = LZ_W'(EXT_W - 1 - i);
      end
   end

   assign lifted = sum[EXT_W-1:0] << lz;

   always_comb begin
      if (carry) begin
         man   = sum[EXT_W:GRD_W+1];
         exp_s = $signed({2'b00, base_exp}) + ES_W'(1);
      end else begin
         man   = lifted[EXT_W-1:GRD_W];
         exp_s = $signed({2'b00, base_exp}) - $signed(ES_W'(lz));
      end
   end

   always_comb begin
      ovf  = 1'b0;
      unf  = 1'b0;
      word = '0;
      if (!is_zero) begin
         if (exp_s > EXP_TOP) begin
            ovf  = 1'b1;
            word = {sign, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
         end else if (exp_s < 0) begin
            unf  = 1'b1;
         end else begin
            word = {sign, exp_s[EXP_W-1:0], man};
         end
      end
   end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub #(
   parameter int unsigned EXP_W   = 10,
   parameter int unsigned MAN_W   = 21,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned WORD_W = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic              op_sub,
   output logic [WORD_W-1:0] res,
   output logic              ovf,
   output logic              unf
);
   import fpas_pkg::*;

   localparam int unsigned GRD_W = FPAS_GRD;
   localparam int unsigned EXT_W = MAN_W + GRD_W;

   if (EXP_W < 2)  begin : g_bad_exp  $error("EXP_W must be at least 2");  end
   if (MAN_W < 4)  begin : g_bad_man  $error("MAN_W must be at least 4");  end
   if ((1 << EXP_W) <= EXT_W) begin : g_bad_gap
      $error("exponent range too small for the alignment width");
   end

   logic             big_sign;
   logic [EXP_W-1:0] big_exp, exp_gap;
   logic [MAN_W-1:0] big_man, small_man;
   mag_op_e          mag_op;
   logic [EXT_W-1:0] small_ext;
   logic [EXT_W:0]   mag_sum;
   logic [WORD_W-1:0] nx_res;
   logic             nx_ovf, nx_unf;

   fpas_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
      .a_word(op_a), .b_word(op_b), .sub_req(op_sub),
      .big_sign(big_sign), .big_exp(big_exp), .big_man(big_man),
      .small_man(small_man), .exp_gap(exp_gap), .mag_op(mag_op)
   );

   fpas_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_align (
      .man_in(small_man), .shift(exp_gap), .ext_out(small_ext)
   );

   always_comb begin
      if (mag_op == MAG_SUB)
         mag_sum = {1'b0, big_man, {GRD_W{1'b0}}} - {1'b0, small_ext};
      else
         mag_sum = {1'b0, big_man, {GRD_W{1'b0}}} + {1'b0, small_ext};
   end

   fpas_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_norm (
      .sum(mag_sum), .base_exp(big_exp), .sign(big_sign),
      .word(nx_res), .ovf(nx_ovf), .unf(nx_unf)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
         end else begin
            res <= nx_res;
            ovf <= nx_ovf;
            unf <= nx_unf;
         end
      end
   end else begin : g_comb
      assign res = nx_res;
      assign ovf = nx_ovf;
      assign unf = nx_unf;
   end
endmodule

// File: rtl/fpas_check.sv
module fpas_check #(
   parameter int unsigned EXP_W   = 10,
   parameter int unsigned MAN_W   = 21,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned WORD_W = 1 + EXP_W + MAN_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] op_a,
   input logic [WORD_W-1:0] op_b,
   input logic              op_sub,
   input logic [WORD_W-1:0] res,
   input logic              ovf,
   input logic              unf
);
   // R11: flags are mutually exclusive
   a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && unf));

   // R9: overflow output is the saturated magnitude
   a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (res[WORD_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b1}}}));

   // R10: underflow output is flushed to the zero word
   a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
      unf |-> (res == '0));

   // R6: every nonzero output is normalized
   a_r6_normalized: assert property (@(posedge clk) disable iff (!rst_n)
      (res != '0) |-> res[MAN_W-1]);

   if (OUT_REG) begin : g_seq
      // R7: zero op_a passes op_b through with the sign adjusted for op_sub
      a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
         ((op_a[MAN_W-1:0] == '0) && op_b[MAN_W-1])
         |=> (res == {$past(op_b[WORD_W-1] ^ op_sub), $past(op_b[WORD_W-2:0])})
             && !ovf && !unf);
      // R8: subtracting a word from itself gives the zero word
      a_r8_self_cancel: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sub && (op_a == op_b)) |=> (res == '0) && !ovf && !unf);
   end else begin : g_comb
      a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
         ((op_a[MAN_W-1:0] == '0) && op_b[MAN_W-1])
         |-> (res == {op_b[WORD_W-1] ^ op_sub, op_b[WORD_W-2:0]}));
      a_r8_self_cancel: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sub && (op_a == op_b)) |-> (res == '0) && !ovf && !unf);
   end
endmodule

bind fp_addsub fpas_check #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_fp_addsub.sv
`timescale 1ns/1ps
module sim_fp_addsub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        op_sub = 1'b0;
   logic [31:0] res;
   logic        ovf, unf;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fp_addsub u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
                 .op_sub(op_sub), .res(res), .ovf(ovf), .unf(unf));

   function automatic logic [31:0] w(input logic s, input int eb, input logic [20:0] m);
      return {s, 10'(eb), m};
   endfunction

   task automatic chk(input string req, input logic [33:0] got, input logic [33:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got ovf/unf/res=%b/%b/%h expected %b/%b/%h",
                  req, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
      end
   endtask

   // Drive on a falling edge; the result is registered at the next rising
   // edge and sampled on the falling edge after that.
   task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic s, input logic [31:0] er, input logic eo, input logic eu);
      @(negedge clk);
      op_a = a; op_b = b; op_sub = s;
      @(negedge clk);
      chk(req, {ovf, unf, res}, {eo, eu, er});
   endtask

   task automatic t_reset;
      op_a = w(0, 600, 21'h1FFFFF); op_b = w(0, 600, 21'h1FFFFF);
      repeat (3) @(negedge clk);
      chk("R2 reset", {ovf, unf, res}, 34'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 first result after reset", {ovf, unf, res}, {2'b00, w(0, 601, 21'h1FFFFF)});
   endtask

   task automatic t_align;
      run("R1 R5 carry 0.5+0.5", w(0,512,21'h100000), w(0,512,21'h100000), 0, w(0,513,21'h100000), 0, 0);
      run("R3 align by 2", w(0,514,21'h100000), w(0,512,21'h100000), 0, w(0,514,21'h140000), 0, 0);
      run("R3 truncation on add", w(0,512,21'h100000), w(0,511,21'h100001), 0, w(0,512,21'h180000), 0, 0);
      run("R3 sticky on subtract", w(0,512,21'h100000), w(0,482,21'h1FFFFF), 1, w(0,511,21'h1FFFFF), 0, 0);
   endtask

   task automatic t_sign;
      run("R4 R6 0.5-0.75", w(0,512,21'h100000), w(0,512,21'h180000), 1, w(1,511,21'h100000), 0, 0);
      run("R4 larger negative a", w(1,512,21'h180000), w(0,512,21'h100000), 0, w(1,511,21'h100000), 0, 0);
      run("R4 larger negative b", w(0,510,21'h100000), w(1,512,21'h100000), 0, w(1,511,21'h180000), 0, 0);
      run("R4 sub of negative b", w(0,512,21'h100000), w(1,512,21'h100000), 1, w(0,513,21'h100000), 0, 0);
   endtask

   task automatic t_norm;
      run("R6 cancel to one bit", w(0,512,21'h100001), w(0,512,21'h100000), 1, w(0,492,21'h100000), 0, 0);
      run("R8 self cancel", w(0,600,21'h123456), w(0,600,21'h123456), 1, 32'd0, 0, 0);
      run("R8 opposite signs cancel", w(1,77,21'h1ABCDE), w(0,77,21'h1ABCDE), 0, 32'd0, 0, 0);
   endtask

   task automatic t_zero;
      run("R7 zero a with odd exponent", w(1,700,21'h0), w(0,3,21'h1ABCDE), 0, w(0,3,21'h1ABCDE), 0, 0);
      run("R7 zero a, subtract", w(0,700,21'h0), w(0,3,21'h1ABCDE), 1, w(1,3,21'h1ABCDE), 0, 0);
      run("R7 zero b large exponent", w(0,900,21'h155555), w(0,1000,21'h0), 1, w(0,900,21'h155555), 0, 0);
      run("R7 both zero", w(1,5,21'h0), w(0,1023,21'h0), 0, 32'd0, 0, 0);
   endtask

   task automatic t_range;
      run("R9 overflow positive", w(0,1023,21'h1FFFFF), w(0,1023,21'h1FFFFF), 0, w(0,1023,21'h1FFFFF), 1, 0);
      run("R9 overflow negative", w(1,1023,21'h100000), w(1,1023,21'h100000), 0, w(1,1023,21'h1FFFFF), 1, 0);
      run("R11 top exponent in range", w(0,1023,21'h100000), w(0,1022,21'h100000), 0, w(0,1023,21'h180000), 0, 0);
      run("R10 underflow deep", w(0,0,21'h100001), w(0,0,21'h100000), 1, 32'd0, 0, 1);
      run("R10 underflow by one", w(0,0,21'h180000), w(0,0,21'h100000), 1, 32'd0, 0, 1);
      run("R11 lowest exponent in range", w(0,1,21'h180000), w(0,1,21'h100000), 1, w(0,0,21'h100000), 0, 0);
   endtask

   initial begin
      t_reset();
      t_align();
      t_sign();
      t_norm();
      t_zero();
      t_range();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule